// File: doc/BRIEF.md
# USB Root Port Status and Control Register

This block holds the status and control fields of one downstream root port in a USB 2.0 host. Software reaches it through a flat register interface: one write strobe with a 7-bit write word, and a 7-bit read word that always shows the current fields. The hardware side feeds it a raw connect-detect line, a raw overcurrent line, the two-bit bus line state, a suspend indication, a reset-complete strobe with a high-speed flag, and a strobe for a fault seen at the end-of-frame point.

The block keeps the change bits sticky until software clears them by writing a 1. It lets only hardware turn the port on. It also runs the resume handshake. A remote wake seen on a suspended port starts resume signalling and sends a one-cycle pulse to the global status logic. Resume started by software sends no pulse. When software ends resume, the field stays set until the line reaches high-speed idle, and a bounded timer forces it clear if the line never gets there. When the port is unpowered, every field reads as zero and the internal state is cleared.

Top module: `usb_root_port_status`

## Requirements
- R1: After reset every field reads 0. The read word uses these bit positions: bit 0 connected, bit 1 connect changed, bit 2 enabled, bit 3 enable changed, bit 4 overcurrent present, bit 5 overcurrent changed, bit 6 resume.
- R2: While `port_power` is 0, `reg_rd_data` is 0 and `data_pass`, `resume_drive_k` and `port_change_pulse` stay low. All state is cleared, so when power returns, a device that is already attached produces a fresh connect change.
- R3: Bits 1 and 5 are set on every change of the bit they track. They stay set if more changes arrive before software clears them. A write with the bit at 1 clears it. When a set event and a clearing write hit the same cycle, the bit ends up set.
- R4: A software write of 1 to bit 2 has no effect and a write of 0 clears it. A `reset_done` strobe loads bit 2 with `reset_hs`, so only a reset that finds a high-speed device enables the port.
- R5: Bit 3 is set only when `eof_fault` disables a port that is enabled. A software disable does not set it. A write of 1 to bit 3 clears it.
- R6: Bit 4 follows `overcurrent_in` after the synchroniser and returns to 0 by itself when the input falls.
- R7: Line state uses 00 for SE0 (high-speed idle), 01 for J and 10 for K. A J-to-K step while `suspended` is 1 sets bit 6 and gives exactly one one-cycle `port_change_pulse`. A write of 1 to bit 6 sets it with no pulse. A J-to-K step while not suspended is ignored.
- R8: `resume_drive_k` is high while resume is being driven. After software writes 0 to bit 6, `resume_drive_k` drops but bit 6 stays 1 until the line shows SE0.
- R9: If SE0 is not seen, bit 6 is forced to 0 exactly `CLK_KHZ*TIMEOUT_US/1000` cycles after the write of 0.
- R10: `data_pass` is high only while the port is enabled and powered.
- R11: `connect_in` passes through a `SYNC_STAGES`-deep synchroniser. Each real transition produces exactly one change event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_power | input | 1 | Port power control bit from the port power logic |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 7 | Register write word |
| reg_rd_data | output | 7 | Register read word |
| connect_in | input | 1 | Raw device-present line |
| overcurrent_in | input | 1 | Raw overcurrent line |
| line_state | input | 2 | Bus line state (00 SE0, 01 J, 10 K) |
| suspended | input | 1 | Port is in suspend |
| reset_done | input | 1 | Port reset sequence finished (one cycle) |
| reset_hs | input | 1 | Reset found a high-speed device, valid with reset_done |
| eof_fault | input | 1 | Fault seen at the end-of-frame point (one cycle) |
| resume_drive_k | output | 1 | Drive full-speed K on the port |
| data_pass | output | 1 | Downstream data allowed |
| port_change_pulse | output | 1 | One-cycle port change detect to global status |

## Verification
The assertions take `line_state`, `suspended`, `reset_done`, `reset_hs` and `eof_fault` to be synchronous to `clk`. Only `connect_in` and `overcurrent_in` may be asynchronous. They also take `reset_done` and `eof_fault` to be single-cycle strobes. The bench changes every input on the falling edge and raises each strobe for exactly one cycle. It also follows the read-modify-write habit: any write made while resume is being driven keeps bit 6 at 1, unless that write is meant to end resume.

// File: rtl/prs_pkg.sv
// Package: shared field positions and encodings for the root port status register.
// Assumes: a 7-bit register word; the line state is a two-bit synchronous code.
package prs_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned FIELD_W      = 7;
    localparam int unsigned BIT_CONN     = 0;
    localparam int unsigned BIT_CONN_CHG = 1;
    localparam int unsigned BIT_EN       = 2;
    localparam int unsigned BIT_EN_CHG   = 3;
    localparam int unsigned BIT_OC       = 4;
    localparam int unsigned BIT_OC_CHG   = 5;
    localparam int unsigned BIT_RESUME   = 6;
    localparam int unsigned NUM_STICKY   = 3;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [1:0] {
        RES_IDLE  = 2'b00,
        RES_DRIVE = 2'b01,
        RES_EXIT  = 2'b10
    } res_state_t;
endpackage

// File: rtl/prs_sync_edge.sv
// Module: multi-flop synchroniser with a toggle output.
// Drives a clean copy of an asynchronous level and flags the cycle in which
// the clean copy changes. The flag comes from the last two flops, so one real
// transition makes exactly one flagged cycle.
// Assumes: STAGES >= 2; clear empties the chain (used while unpowered).
module prs_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic async_in,
    output logic sync_out,
    output logic toggle
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];
    assign toggle   = chain_q[STAGES-1] ^ chain_q[STAGES-2];
endmodule

// File: rtl/prs_sticky_bit.sv
// Module: sticky change bit, cleared by writing 1.
// A set event takes priority over a clearing write in the same cycle, so no
// event is lost. force_clr empties the bit when the port is unpowered.
// Assumes: clr_req is already qualified with the write strobe.
module prs_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic force_clr,
    input  logic set_evt,
    input  logic clr_req,
    output logic q
);
    timeunit 1ns;
    timeprecision 1ps;

    // Hold, set or clear the change flag.
    always_ff @(posedge clk) begin
        if (!rst_n || force_clr) begin
            q <= 1'b0;
        end else if (set_evt) begin
            q <= 1'b1;
        end else if (clr_req) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/prs_resume_ctrl.sv
// Module: resume handshake controller.
// IDLE -> DRIVE on a remote wake (J-to-K while suspended) or a software set.
// DRIVE -> EXIT when software writes 0. EXIT -> IDLE on SE0 or after LIMIT
// cycles. Only the remote wake path raises wake_pulse.
// Assumes: line_state is synchronous; LIMIT >= 2.
module prs_resume_ctrl
    import prs_pkg::*;
#(
    parameter int unsigned LIMIT = 400000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_idle,
    input  logic       suspended,
    input  logic [1:0] line_state,
    input  logic       sw_wr,
    input  logic       sw_val,
    output logic       resume_bit,
    output logic       drive_k,
    output logic       wake_pulse
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    res_state_t st_q, st_nxt;
    logic [TW-1:0] timer_q;
    logic [1:0]    prev_q;
    logic          hw_jk;

    // Remote wake: J on the previous cycle, K now, while suspended.
    assign hw_jk = suspended && (prev_q == LS_J) && (line_state == LS_K);

    // Next-state choice for the resume handshake.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            RES_IDLE:  if (hw_jk || (sw_wr && sw_val)) st_nxt = RES_DRIVE;
            RES_DRIVE: if (sw_wr && !sw_val)           st_nxt = RES_EXIT;
            RES_EXIT:  if ((line_state == LS_SE0) || (timer_q == LAST)) st_nxt = RES_IDLE;
            default:   st_nxt = RES_IDLE;
        endcase
    end

    // State, exit timer, wake pulse and previous line state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= RES_IDLE;
            timer_q    <= '0;
            wake_pulse <= 1'b0;
            prev_q     <= LS_SE0;
        end else if (force_idle) begin
            st_q       <= RES_IDLE;
            timer_q    <= '0;
            wake_pulse <= 1'b0;
            prev_q     <= line_state;
        end else begin
            st_q       <= st_nxt;
            wake_pulse <= (st_q == RES_IDLE) && hw_jk;
            timer_q    <= ((st_q == RES_EXIT) && (st_nxt == RES_EXIT)) ? timer_q + 1'b1 : '0;
            prev_q     <= line_state;
        end
    end

    assign resume_bit = (st_q != RES_IDLE);
    assign drive_k    = (st_q == RES_DRIVE);
endmodule

// File: rtl/usb_root_port_status.sv
// Module: status and control register for one USB 2.0 root port.
// Synchronises the connect and overcurrent lines, keeps three sticky change
// bits, allows hardware-only enabling, and runs the resume handshake with a
// bounded exit. Every field reads 0 and all state clears while unpowered.
// Assumes: reset_done and eof_fault are one-cycle synchronous strobes.
module usb_root_port_status
    import prs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CLK_KHZ     = 200000,
    parameter int unsigned TIMEOUT_US  = 2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_power,
    input  logic               reg_wr_en,
    input  logic [FIELD_W-1:0] reg_wr_data,
    output logic [FIELD_W-1:0] reg_rd_data,
    input  logic               connect_in,
    input  logic               overcurrent_in,
    input  logic [1:0]         line_state,
    input  logic               suspended,
    input  logic               reset_done,
    input  logic               reset_hs,
    input  logic               eof_fault,
    output logic               resume_drive_k,
    output logic               data_pass,
    output logic               port_change_pulse
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned EXIT_LIMIT = (CLK_KHZ * TIMEOUT_US) / 1000;

    logic                  unpowered;
    logic                  conn_sync, conn_tog;
    logic                  oc_sync, oc_tog;
    logic                  en_q;
    logic                  fault_disable;
    logic [NUM_STICKY-1:0] chg_set, chg_clr, chg_q;
    logic                  resume_bit;
    logic                  unused_ro_bits;
    logic [FIELD_W-1:0]    fields;

    assign unpowered = !port_power;

    // Read-only positions of the write word carry no meaning.
    assign unused_ro_bits = reg_wr_data[BIT_CONN] ^ reg_wr_data[BIT_OC];

    // One synchroniser per asynchronous status line.
    prs_sync_edge #(.STAGES(SYNC_STAGES)) conn_sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (unpowered),
        .async_in (connect_in),
        .sync_out (conn_sync),
        .toggle   (conn_tog)
    );

    prs_sync_edge #(.STAGES(SYNC_STAGES)) oc_sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (unpowered),
        .async_in (overcurrent_in),
        .sync_out (oc_sync),
        .toggle   (oc_tog)
    );

    // Hardware disables an enabled port on an end-of-frame fault.
    assign fault_disable = port_power && !reset_done && eof_fault && en_q;

    // Port enable: set only by a high-speed reset result, cleared by a fault or software.
    always_ff @(posedge clk) begin
        if (!rst_n || unpowered) begin
            en_q <= 1'b0;
        end else if (reset_done) begin
            en_q <= reset_hs;
        end else if (eof_fault) begin
            en_q <= 1'b0;
        end else if (reg_wr_en && !reg_wr_data[BIT_EN]) begin
            en_q <= 1'b0;
        end
    end

    // Sticky change bits, index 0 connect, 1 enable, 2 overcurrent.
    assign chg_set = {oc_tog, fault_disable, conn_tog};
    assign chg_clr = {reg_wr_data[BIT_OC_CHG], reg_wr_data[BIT_EN_CHG],
                      reg_wr_data[BIT_CONN_CHG]} & {NUM_STICKY{reg_wr_en}};

    for (genvar g = 0; g < NUM_STICKY; g++) begin : g_chg
        prs_sticky_bit chg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .force_clr (unpowered),
            .set_evt   (chg_set[g]),
            .clr_req   (chg_clr[g]),
            .q         (chg_q[g])
        );
    end

    prs_resume_ctrl #(.LIMIT(EXIT_LIMIT)) resume_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_idle (unpowered),
        .suspended  (suspended),
        .line_state (line_state),
        .sw_wr      (reg_wr_en),
        .sw_val     (reg_wr_data[BIT_RESUME]),
        .resume_bit (resume_bit),
        .drive_k    (resume_drive_k),
        .wake_pulse (port_change_pulse)
    );

    // Assemble the read word; zero while unpowered.
    always_comb begin
        fields               = '0;
        fields[BIT_CONN]     = conn_sync;
        fields[BIT_CONN_CHG] = chg_q[0];
        fields[BIT_EN]       = en_q;
        fields[BIT_EN_CHG]   = chg_q[1];
        fields[BIT_OC]       = oc_sync;
        fields[BIT_OC_CHG]   = chg_q[2];
        fields[BIT_RESUME]   = resume_bit;
    end

    assign reg_rd_data = port_power ? fields : '0;
    assign data_pass   = en_q && port_power;
endmodule

// File: rtl/prs_checker.sv
// Module: property checker for the root port status register, bound to the top.
// Assumes: strobes are single-cycle and synchronous (see the brief).
module prs_checker #(
    parameter int unsigned LIMIT = 400000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       port_power,
    input logic       reg_wr_en,
    input logic [6:0] reg_wr_data,
    input logic [6:0] reg_rd_data,
    input logic [1:0] line_state,
    input logic       suspended,
    input logic       reset_done,
    input logic       reset_hs,
    input logic       eof_fault,
    input logic       resume_drive_k,
    input logic       data_pass,
    input logic       port_change_pulse
);
    timeunit 1ns;
    timeprecision 1ps;

    int unsigned exit_cnt;

    // Count cycles spent with resume set but K no longer driven.
    always_ff @(posedge clk) begin
        if (!rst_n || !(reg_rd_data[6] && !resume_drive_k)) begin
            exit_cnt <= 0;
        end else begin
            exit_cnt <= exit_cnt + 1;
        end
    end

    AST_UNPOWERED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !port_power |=> (!data_pass && !resume_drive_k && !port_change_pulse)); // R2

    AST_CHANGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (port_power && reg_rd_data[1] && !(reg_wr_en && reg_wr_data[1]))
        |=> (reg_rd_data[1] || !port_power)); // R3

    AST_ENABLE_BY_HS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rd_data[2]) |-> $past(reset_done && reset_hs)); // R4

    AST_ENCHG_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rd_data[3]) |-> $past(eof_fault)); // R5

    AST_WAKE_NEEDS_JK: assert property (@(posedge clk) disable iff (!rst_n)
        port_change_pulse |-> $past(suspended && (line_state == 2'b10))); // R7

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        port_change_pulse |=> !port_change_pulse); // R7

    AST_K_WITH_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        resume_drive_k |-> reg_rd_data[6]); // R8

    AST_EXIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        exit_cnt <= LIMIT); // R9
endmodule

bind usb_root_port_status prs_checker #(.LIMIT(EXIT_LIMIT)) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .port_power        (port_power),
    .reg_wr_en         (reg_wr_en),
    .reg_wr_data       (reg_wr_data),
    .reg_rd_data       (reg_rd_data),
    .line_state        (line_state),
    .suspended         (suspended),
    .reset_done        (reset_done),
    .reset_hs          (reset_hs),
    .eof_fault         (eof_fault),
    .resume_drive_k    (resume_drive_k),
    .data_pass         (data_pass),
    .port_change_pulse (port_change_pulse)
);

// File: tb/usb_root_port_status_tb_top.sv
// Directed bench for the root port status register; one task per scenario.
module usb_root_port_status_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned LIMIT = 20;   // 1000 kHz * 20 us / 1000

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_power = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [6:0] reg_wr_data = '0;
    logic [6:0] reg_rd_data;
    logic       connect_in = 1'b0;
    logic       overcurrent_in = 1'b0;
    logic [1:0] line_state = 2'b01;
    logic       suspended = 1'b0;
    logic       reset_done = 1'b0;
    logic       reset_hs = 1'b0;
    logic       eof_fault = 1'b0;
    logic       resume_drive_k;
    logic       data_pass;
    logic       port_change_pulse;

    int errors = 0;
    int checks = 0;
    int pcd_count = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_root_port_status #(
        .SYNC_STAGES (2),
        .CLK_KHZ     (1000),
        .TIMEOUT_US  (20)
    ) dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .port_power        (port_power),
        .reg_wr_en         (reg_wr_en),
        .reg_wr_data       (reg_wr_data),
        .reg_rd_data       (reg_rd_data),
        .connect_in        (connect_in),
        .overcurrent_in    (overcurrent_in),
        .line_state        (line_state),
        .suspended         (suspended),
        .reset_done        (reset_done),
        .reset_hs          (reset_hs),
        .eof_fault         (eof_fault),
        .resume_drive_k    (resume_drive_k),
        .data_pass         (data_pass),
        .port_change_pulse (port_change_pulse)
    );

    always @(negedge clk) if (rst_n && port_change_pulse) pcd_count++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [6:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic pulse_reset(input logic hs);
        @(negedge clk);
        reset_done = 1'b1;
        reset_hs = hs;
        @(negedge clk);
        reset_done = 1'b0;
        reset_hs = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        wait_n(1);
        chk("R1 read word after reset", reg_rd_data, 7'h00);
        chk("R1 outputs after reset", {resume_drive_k, data_pass, port_change_pulse}, 3'b000);
    endtask

    task automatic t_connect;
        @(negedge clk) connect_in = 1'b1;
        wait_n(4);
        chk("R11 R1 connect and change bits", reg_rd_data, 7'b0000011);
        do_write(7'b0000010);
        wait_n(3);
        chk("R11 single change event per transition", reg_rd_data, 7'b0000001);
        @(negedge clk) connect_in = 1'b0;
        wait_n(4);
        @(negedge clk) connect_in = 1'b1;
        wait_n(4);
        chk("R3 change stays set over two transitions", reg_rd_data, 7'b0000011);
        do_write(7'b0000010);
        chk("R3 write one clears connect change", reg_rd_data, 7'b0000001);
    endtask

    task automatic t_overcurrent;
        @(negedge clk) overcurrent_in = 1'b1;
        wait_n(4);
        chk("R6 overcurrent present", reg_rd_data[5:4], 2'b11);
        @(negedge clk) overcurrent_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = 7'b0100000;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wr_data = '0;
        chk("R3 set wins over same-cycle clear", reg_rd_data[5], 1'b1);
        chk("R6 overcurrent clears by itself", reg_rd_data[4], 1'b0);
        do_write(7'b0100000);
        chk("R3 write one clears overcurrent change", reg_rd_data[5], 1'b0);
    endtask

    task automatic t_enable;
        do_write(7'b0000100);
        chk("R4 software write of one does not enable", reg_rd_data[2], 1'b0);
        pulse_reset(1'b0);
        chk("R4 full-speed reset result stays disabled", reg_rd_data[2], 1'b0);
        pulse_reset(1'b1);
        chk("R4 high-speed reset enables", reg_rd_data[2], 1'b1);
        chk("R10 data passes when enabled", data_pass, 1'b1);
        @(negedge clk) eof_fault = 1'b1;
        @(negedge clk) eof_fault = 1'b0;
        chk("R5 fault disables and flags", reg_rd_data[3:2], 2'b10);
        chk("R10 data blocked when disabled", data_pass, 1'b0);
        do_write(7'b0001000);
        chk("R5 write one clears enable change", reg_rd_data[3], 1'b0);
        pulse_reset(1'b1);
        do_write(7'b0000000);
        chk("R5 R4 software disable sets no change", reg_rd_data[3:2], 2'b00);
    endtask

    task automatic t_resume_hw;
        int base;
        base = pcd_count;
        @(negedge clk) begin suspended = 1'b1; line_state = 2'b01; end
        wait_n(2);
        @(negedge clk) line_state = 2'b10;
        wait_n(3);
        chk("R7 remote wake gives one pulse", pcd_count - base, 1);
        chk("R7 remote wake sets resume", reg_rd_data[6], 1'b1);
        chk("R8 K driven while resume set", resume_drive_k, 1'b1);
        do_write(7'b1000000);
        do_write(7'b0000000);
        wait_n(2);
        chk("R8 resume holds until idle", {reg_rd_data[6], resume_drive_k}, 2'b10);
        @(negedge clk) line_state = 2'b00;
        wait_n(2);
        chk("R8 resume clears on SE0", reg_rd_data[6], 1'b0);
        @(negedge clk) begin suspended = 1'b0; line_state = 2'b01; end
        wait_n(2);
        base = pcd_count;
        @(negedge clk) line_state = 2'b10;
        wait_n(3);
        chk("R7 J-to-K ignored when not suspended", {reg_rd_data[6], 1'b0}, 2'b00);
        chk("R7 no pulse when not suspended", pcd_count - base, 0);
        @(negedge clk) line_state = 2'b01;
    endtask

    task automatic t_resume_sw;
        int base;
        base = pcd_count;
        do_write(7'b1000000);
        wait_n(1);
        chk("R7 software resume sets bit", {reg_rd_data[6], resume_drive_k}, 2'b11);
        chk("R7 software resume gives no pulse", pcd_count - base, 0);
        do_write(7'b0000000);
        wait_n(LIMIT - 4);
        chk("R9 resume held before timeout", reg_rd_data[6], 1'b1);
        wait_n(8);
        chk("R9 resume forced clear at timeout", reg_rd_data[6], 1'b0);
    endtask

    task automatic t_power;
        pulse_reset(1'b1);
        @(negedge clk) port_power = 1'b0;
        wait_n(1);
        chk("R2 unpowered reads zero", reg_rd_data, 7'h00);
        chk("R2 unpowered outputs low", {data_pass, resume_drive_k}, 2'b00);
        wait_n(2);
        @(negedge clk) port_power = 1'b1;
        wait_n(4);
        chk("R2 fresh connect change after power-up", reg_rd_data, 7'b0000011);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_connect();
        t_overcurrent();
        t_enable();
        t_resume_hw();
        t_resume_sw();
        t_power();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule